// File: doc/BRIEF.md
# Windowed Processor Watchdog Controller

This block supervises a processor through a windowed watchdog. Once the reset generator releases the processor, the controller first runs an ignore window. During that window, trigger strobes have no effect. An extended first open window follows. After that, closed and open windows alternate. The processor must service the watchdog inside each open window. Servicing too late fails, and servicing while a window is closed also fails. Either failure produces a one-cycle reset request to the reset generator. The controller then stays idle until the next release pulse.

Window lengths are counted in ticks of an external timebase. Two strap pins pick a fast timing set, a slow timing set, or switch the watchdog off. A low-load flag also parks the watchdog. The sequence restarts from the ignore window once the load comes back. Sampling of the trigger pin and the reset delay are handled by neighbouring blocks. This block sees only a validated trigger strobe and a release pulse.

Top module: `win_watchdog`

## Requirements
- R1: After `rstN` deasserts, `rstReq` is 0. No request is ever raised until a `relPulse` has been seen.
- R2: A release pulse starts the ignore window, which lasts one base length of ticks (FAST_TICKS or SLOW_TICKS). A trigger sampled anywhere in it, including on its final tick, is ignored.
- R3: The ignore window is followed by a first open window of LONG_MULT base lengths. If it expires with no trigger, a request is raised. In fast mode with one tick per cycle, that request follows the 160th clock edge after the release edge.
- R4: A trigger sampled in any open window, long or normal, immediately starts a closed window of one base length.
- R5: A trigger sampled in a closed window raises a request on the next edge. This includes a trigger on the window's final tick.
- R6: When a closed window expires, a normal open window of one base length starts. If it expires with no trigger, a request is raised. A trigger on its final tick counts as on time.
- R7: `modeSel` = {first strap, second strap} selects the mode. 2'b00 is fast, 2'b01 is slow, 2'b10 is fast, and 2'b11 is off. In the off mode no request is raised. Leaving the off mode re-enters the ignore window.
- R8: While `lowLoad` is 1, the watchdog is parked and raises no request. When `lowLoad` returns to 0, the ignore window restarts.
- R9: `rstReq` is a one-cycle registered pulse. After it, the controller is idle and raises nothing more until the next `relPulse`.
- R10: Window counters advance only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe; each high cycle is one window tick |
| relPulse | input | 1 | One-cycle pulse when the processor reset is released |
| trigValid | input | 1 | One-cycle strobe for a validated service trigger |
| modeSel | input | 2 | Strap pins: {first, second}, selecting fast, slow or off |
| lowLoad | input | 1 | High while load current is below the watchdog threshold |
| rstReq | output | 1 | One-cycle reset request to the reset generator |

## Verification
The assertions treat `trigValid` and `relPulse` as one-cycle strobes that are already debounced. They expect the strap pins to change only while the watchdog is idle or parked, since the window length is captured when each window starts. The directed stimulus raises every strobe for exactly one cycle. It moves `modeSel` only before a release or while the off mode holds the controller parked. Triggers are placed on chosen edges, so each window boundary is hit on its final tick.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IGNORE,
    ST_LONG,
    ST_CLOSED,
    ST_OPEN,
    ST_PARKED
  } wdState_t;

  typedef struct packed {
    logic loadBase;
    logic loadLong;
  } winCtl_t;

endpackage

// File: rtl/wwd_timer.sv
module wwd_timer
  import wwd_pkg::*;
#(
  parameter int FAST_TICKS = 32,
  parameter int SLOW_TICKS = 64,
  parameter int LONG_MULT  = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    slowSel,
  input  winCtl_t ctl,
  output logic    expire
);

  localparam int MAX_BASE = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int CW = $clog2(MAX_BASE * LONG_MULT + 1);
  localparam logic [CW-1:0] FAST_B = CW'(FAST_TICKS);
  localparam logic [CW-1:0] SLOW_B = CW'(SLOW_TICKS);
  localparam logic [CW-1:0] FAST_L = CW'(FAST_TICKS * LONG_MULT);
  localparam logic [CW-1:0] SLOW_L = CW'(SLOW_TICKS * LONG_MULT);

  logic [CW-1:0] cnt;
  logic [CW-1:0] baseLen;
  logic [CW-1:0] longLen;

  always_comb begin
    baseLen = slowSel ? SLOW_B : FAST_B;
    longLen = slowSel ? SLOW_L : FAST_L;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.loadLong) begin
      cnt <= longLen;
    end else if (ctl.loadBase) begin
      cnt <= baseLen;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = tick && (cnt == CW'(1));

  AST_BASE_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadBase |=> (cnt == FAST_B || cnt == SLOW_B)); // R4

  AST_LONG_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadLong |=> (cnt == FAST_L || cnt == SLOW_L)); // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !ctl.loadBase && !ctl.loadLong) |=> $stable(cnt)); // R10

endmodule

// File: rtl/wwd_ctrl.sv
module wwd_ctrl
  import wwd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    relPulse,
  input  logic    trigValid,
  input  logic    enable,
  input  logic    expire,
  output winCtl_t ctl,
  output logic    rstReq
);

  wdState_t stQ, stD;
  logic     faultD;

  always_comb begin
    stD    = stQ;
    ctl    = '0;
    faultD = 1'b0;
    case (stQ)
      ST_IDLE: begin
        if (relPulse) begin
          if (enable) begin
            stD = ST_IGNORE;
            ctl.loadBase = 1'b1;
          end else begin
            stD = ST_PARKED;
          end
        end
      end
      ST_PARKED: begin
        if (enable) begin
          stD = ST_IGNORE;
          ctl.loadBase = 1'b1;
        end
      end
      default: begin
        if (!enable) begin
          stD = ST_PARKED;
        end else if (relPulse) begin
          stD = ST_IGNORE;
          ctl.loadBase = 1'b1;
        end else begin
          case (stQ)
            ST_IGNORE: begin
              if (expire) begin
                stD = ST_LONG;
                ctl.loadLong = 1'b1;
              end
            end
            ST_LONG, ST_OPEN: begin
              if (trigValid) begin
                stD = ST_CLOSED;
                ctl.loadBase = 1'b1;
              end else if (expire) begin
                faultD = 1'b1;
              end
            end
            ST_CLOSED: begin
              if (trigValid) begin
                faultD = 1'b1;
              end else if (expire) begin
                stD = ST_OPEN;
                ctl.loadBase = 1'b1;
              end
            end
            default: stD = ST_IDLE;
          endcase
          if (faultD) stD = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ    <= ST_IDLE;
      rstReq <= 1'b0;
    end else begin
      stQ    <= stD;
      rstReq <= faultD;
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq); // R9

  AST_IDLE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (stQ == ST_IDLE)); // R9

  AST_EARLY_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_CLOSED && trigValid && enable && !relPulse) |=> rstReq); // R5

  AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !rstReq); // R8

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_IGNORE) |=> !rstReq); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_IDLE) |=> !rstReq); // R1

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwd_pkg::*;
#(
  parameter int FAST_TICKS = 32,
  parameter int SLOW_TICKS = 64,
  parameter int LONG_MULT  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       relPulse,
  input  logic       trigValid,
  input  logic [1:0] modeSel,
  input  logic       lowLoad,
  output logic       rstReq
);

  localparam logic [1:0] MODE_SLOW = 2'b01;
  localparam logic [1:0] MODE_OFF  = 2'b11;

  winCtl_t ctl;
  logic    expire;
  logic    enable;
  logic    slowSel;

  assign enable  = !lowLoad && (modeSel != MODE_OFF);
  assign slowSel = (modeSel == MODE_SLOW);

  wwd_timer #(
    .FAST_TICKS(FAST_TICKS),
    .SLOW_TICKS(SLOW_TICKS),
    .LONG_MULT (LONG_MULT)
  ) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .slowSel(slowSel),
    .ctl    (ctl),
    .expire (expire)
  );

  wwd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .relPulse (relPulse),
    .trigValid(trigValid),
    .enable   (enable),
    .expire   (expire),
    .ctl      (ctl),
    .rstReq   (rstReq)
  );

  AST_OFF_MODE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_OFF) |=> !rstReq); // R7

endmodule

// File: tb/win_watchdog_bench.sv
`timescale 1ns/1ps
module win_watchdog_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic       relPulse = 1'b0;
  logic       trigValid = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       lowLoad = 1'b0;
  logic       rstReq;

  int  checks = 0;
  int  failures = 0;
  bit  halfRate = 1'b0;
  int  trigQ[$];

  always #2.5 clk = ~clk;

  win_watchdog u_win_watchdog (
    .clk(clk), .rstN(rstN), .tick(tick), .relPulse(relPulse),
    .trigValid(trigValid), .modeSel(modeSel), .lowLoad(lowLoad),
    .rstReq(rstReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Release edge becomes edge 0; returns at the following negedge.
  task automatic release_now();
    trigQ.delete();
    relPulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    relPulse = 1'b0;
  endtask

  // Counts edges until a request is seen; 0 if none within maxK.
  task automatic run(input int maxK, output int k);
    k = 0;
    tick = halfRate ? 1'b0 : 1'b1;
    for (int i = 1; i <= maxK; i++) begin
      trigValid = 1'b0;
      foreach (trigQ[j]) if (trigQ[j] == i) trigValid = 1'b1;
      tick = halfRate ? ~tick : 1'b1;
      @(posedge clk);
      @(negedge clk);
      trigValid = 1'b0;
      if (rstReq) begin
        k = i;
        @(posedge clk);
        @(negedge clk);
        check(!rstReq, "R9 pulse width", int'(rstReq), 0);
        break;
      end
    end
    tick = 1'b1;
  endtask

  task automatic t_reset();
    int k;
    check(rstReq == 1'b0, "R1 reset value", int'(rstReq), 0);
    run(300, k);
    check(k == 0, "R1 no request before release", k, 0);
  endtask

  task automatic t_fast_timeout();
    int k;
    modeSel = 2'b00;
    release_now();
    run(500, k);
    check(k == 160, "R3 long open timeout fast", k, 160);
    run(400, k);
    check(k == 0, "R9 idle after request", k, 0);
  endtask

  task automatic t_modes();
    int k;
    modeSel = 2'b01;
    release_now();
    run(800, k);
    check(k == 320, "R7 slow mode 01", k, 320);
    modeSel = 2'b10;
    release_now();
    run(500, k);
    check(k == 160, "R7 fast mode 10", k, 160);
    modeSel = 2'b11;
    release_now();
    run(600, k);
    check(k == 0, "R7 off mode 11", k, 0);
    modeSel = 2'b00;
    @(posedge clk);
    @(negedge clk);
    run(500, k);
    check(k == 160, "R7 leaving off restarts ignore", k, 160);
  endtask

  task automatic t_ignore_trig();
    int k;
    modeSel = 2'b00;
    release_now();
    trigQ = '{5, 32};
    run(500, k);
    check(k == 160, "R2 triggers in ignore window", k, 160);
  endtask

  task automatic t_long_service();
    int k;
    release_now();
    trigQ = '{33};
    run(500, k);
    check(k == 97, "R4 first long-window trigger", k, 97);
  endtask

  task automatic t_closed_trig();
    int k;
    release_now();
    trigQ = '{42, 50};
    run(500, k);
    check(k == 50, "R5 trigger mid closed", k, 50);
    release_now();
    trigQ = '{42, 74};
    run(500, k);
    check(k == 74, "R5 trigger on last closed tick", k, 74);
  endtask

  task automatic t_open_edge();
    int k;
    release_now();
    trigQ = '{42, 106};
    run(500, k);
    check(k == 170, "R6 trigger on last open tick", k, 170);
  endtask

  task automatic t_service();
    int k;
    release_now();
    trigQ = '{42, 90, 138, 186, 234, 282};
    run(600, k);
    check(k == 346, "R6 regular service then missing", k, 346);
  endtask

  task automatic t_low_load();
    int k;
    modeSel = 2'b00;
    release_now();
    run(100, k);
    check(k == 0, "R8 before low load", k, 0);
    lowLoad = 1'b1;
    run(400, k);
    check(k == 0, "R8 parked by low load", k, 0);
    lowLoad = 1'b0;
    @(posedge clk);
    @(negedge clk);
    run(500, k);
    check(k == 160, "R8 restart after load returns", k, 160);
  endtask

  task automatic t_half_tick();
    int k;
    release_now();
    halfRate = 1'b1;
    run(800, k);
    halfRate = 1'b0;
    check(k == 319, "R10 half-rate tick", k, 319);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast_timeout();
    t_modes();
    t_ignore_trig();
    t_long_service();
    t_closed_trig();
    t_open_edge();
    t_service();
    t_low_load();
    t_half_tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule